// File: doc/BRIEF.md
# Variable-Length Command Stream Decoder

This block sits behind an 8-bit host port and turns a raw byte stream into whole commands. The first byte of each command is an opcode, and its numeric range sets how many operand bytes follow. There can be one, two, three or four operand bytes. The operand bytes are gathered most significant first. When the last byte arrives, the block presents the opcode and the operand, zero-extended to 32 bits, on a valid/ready output. The drawing engines downstream take them from there.

One opcode range writes a 16-bit value straight into a file of 64 general registers. The register index comes from the low six opcode bits, and no separate staging command is needed. Values held there are usually signed coordinates (-32768 to 32767). The block stores them as raw 16-bit patterns. A combinational read port lets the consumers fetch any register.

The input side gives a valid/ready handshake per byte. The block takes no byte while a finished command waits to be accepted. Bytes offered while valid is low are never taken.

Top module: `byte_cmd_decoder`

## Requirements
- R1: After reset, outValid is 0, inReady is 1 and every general register reads 0.
- R2: An opcode in 0..127 is followed by one operand byte; outOperand equals that byte with bits 31:8 zero.
- R3: An opcode in 128..191 is followed by two operand bytes, first byte in bits 15:8 and second in bits 7:0; bits 31:16 are zero.
- R4: An opcode in 192..223 is followed by three operand bytes, first byte in bits 23:16; bits 31:24 are zero.
- R5: An opcode in 224..255 is followed by four operand bytes, first byte in bits 31:24.
- R6: A command with opcode in 128..191 writes its 16-bit operand into register opcode[5:0], readable in the cycle outValid first rises. Commands with other opcodes change no register.
- R7: While outValid is 1 and outReady is 0, outValid stays 1, outOpcode and outOperand are unchanged, and inReady is 0. outValid falls only after a cycle with outReady high.
- R8: A byte is taken only in a cycle where inValid and inReady are both 1. Idle cycles anywhere inside a command leave the partial operand intact.
- R9: outValid rises in the cycle after the last operand byte is taken. After the output is accepted, inReady returns to 1 and the next byte taken is decoded as an opcode.
- R10: regRdData shows the register selected by regRdAddr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Byte from host |
| inValid | input | 1 | inByte carries a byte |
| inReady | output | 1 | Block can take a byte this cycle |
| outValid | output | 1 | A complete command is presented |
| outReady | input | 1 | Consumer takes the command |
| outOpcode | output | 8 | Opcode of the presented command |
| outOperand | output | 32 | Operand, zero-extended |
| regRdAddr | input | 6 | General register index to read |
| regRdData | output | 16 | Content of the selected register |

## Verification
The bench aims at the range edges 127/128, 191/192, 223/224 and 255. A length decoder off by one there would eat the next opcode as data, or stop one byte short, and every later command would be misframed. Short commands are sent with junk in the unused high operand bytes, so a missing clear shows up as stale upper bits. Idle gaps inside commands and random stalls on outReady, with junk bytes offered at the same time, catch a shifter that advances without a handshake or an output that changes or accepts input while stalled. Register readback after every command, at the written index and at a random one, catches writes to the wrong entry or writes from non-register opcodes.

// File: rtl/byte_cmd_pkg.sv
package byte_cmd_pkg;

  // Opcode range boundaries; the length of a command follows from them
  localparam logic [7:0] REG_OP_BASE = 8'd128;
  localparam logic [7:0] OP24_BASE   = 8'd192;
  localparam logic [7:0] OP32_BASE   = 8'd224;

  typedef struct packed {
    logic loadOp;      // opcode byte taken, clear operand
    logic takeOperand; // operand byte taken, shift in
    logic regWrite;    // last byte of a register-write command
  } ctrlStrobes_t;

  function automatic logic [2:0] operandBytes(input logic [7:0] op);
    if (op < REG_OP_BASE)    return 3'd1;
    else if (op < OP24_BASE) return 3'd2;
    else if (op < OP32_BASE) return 3'd3;
    else                     return 3'd4;
  endfunction

  function automatic logic isRegOp(input logic [7:0] op);
    return (op >= REG_OP_BASE) && (op < OP24_BASE);
  endfunction

endpackage

// File: rtl/byte_cmd_ctrl.sv
module byte_cmd_ctrl
  import byte_cmd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   inByte,
  input  logic         inValid,
  input  logic         outReady,
  input  logic         heldIsReg,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);

  typedef enum logic [1:0] {ST_OPCODE, ST_OPERAND, ST_EMIT} state_t;

  state_t     state;
  logic [2:0] remaining;
  logic       accept;

  assign inReady  = (state != ST_EMIT);
  assign outValid = (state == ST_EMIT);
  assign accept   = inValid && inReady;

  always_comb begin
    strobes.loadOp      = accept && (state == ST_OPCODE);
    strobes.takeOperand = accept && (state == ST_OPERAND);
    strobes.regWrite    = strobes.takeOperand && (remaining == 3'd1) && heldIsReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_OPCODE;
      remaining <= '0;
    end else begin
      case (state)
        ST_OPCODE: if (accept) begin
          state     <= ST_OPERAND;
          remaining <= operandBytes(inByte);
        end
        ST_OPERAND: if (accept) begin
          remaining <= remaining - 3'd1;
          if (remaining == 3'd1) state <= ST_EMIT;
        end
        ST_EMIT: if (outReady) state <= ST_OPCODE;
        default: state <= ST_OPCODE;
      endcase
    end
  end

endmodule

// File: rtl/byte_cmd_dpath.sv
module byte_cmd_dpath
  import byte_cmd_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int OPER_W  = 32,
  parameter int REG_W   = 16,
  parameter int REG_CNT = 64,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [BYTE_W-1:0] opcodeQ,
  output logic [OPER_W-1:0] operandQ,
  output logic              heldIsReg,
  output logic [REG_W-1:0]  regRdData
);

  logic [REG_W-1:0] regArr [REG_CNT];
  logic [REG_W-1:0] regWrData;

  assign heldIsReg = isRegOp(opcodeQ);
  assign regWrData = {operandQ[REG_W-BYTE_W-1:0], inByte};
  assign regRdData = regArr[regRdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeQ  <= '0;
      operandQ <= '0;
    end else if (strobes.loadOp) begin
      opcodeQ  <= inByte;
      operandQ <= '0;
    end else if (strobes.takeOperand) begin
      operandQ <= {operandQ[OPER_W-BYTE_W-1:0], inByte};
    end
  end

  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regArr[i] <= '0;
      else if (strobes.regWrite && (opcodeQ[ADDR_W-1:0] == ADDR_W'(i)))
        regArr[i] <= regWrData;
    end
  end

endmodule

// File: rtl/byte_cmd_decoder.sv
module byte_cmd_decoder
  import byte_cmd_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int OPER_W  = 32,
  parameter int REG_W   = 16,
  parameter int REG_CNT = 64,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inValid,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [BYTE_W-1:0] outOpcode,
  output logic [OPER_W-1:0] outOperand,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [REG_W-1:0]  regRdData
);

  ctrlStrobes_t strobes;
  logic         heldIsReg;

  byte_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inByte    (inByte),
    .inValid   (inValid),
    .outReady  (outReady),
    .heldIsReg (heldIsReg),
    .inReady   (inReady),
    .outValid  (outValid),
    .strobes   (strobes)
  );

  byte_cmd_dpath #(
    .BYTE_W  (BYTE_W),
    .OPER_W  (OPER_W),
    .REG_W   (REG_W),
    .REG_CNT (REG_CNT)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .inByte    (inByte),
    .strobes   (strobes),
    .regRdAddr (regRdAddr),
    .opcodeQ   (outOpcode),
    .operandQ  (outOperand),
    .heldIsReg (heldIsReg),
    .regRdData (regRdData)
  );

endmodule

// File: rtl/byte_cmd_checker.sv
module byte_cmd_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [7:0]        outOpcode,
  input logic [31:0]       outOperand,
  input logic [ADDR_W-1:0] regRdAddr,
  input logic [15:0]       regRdData
);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outOpcode) && $stable(outOperand))); // R7

  AST_NO_INPUT_WHILE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R7

  AST_DROP_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outReady)); // R7

  AST_SHORT_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOpcode < 8'd128) |-> (outOperand[31:8] == 24'd0)); // R2

  AST_REG_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOpcode >= 8'd128 && outOpcode < 8'd192) |-> (outOperand[31:16] == 16'd0)); // R3

  AST_WIDE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOpcode >= 8'd192 && outOpcode < 8'd224) |-> (outOperand[31:24] == 8'd0)); // R4

  AST_REG_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outValid) && outOpcode >= 8'd128 && outOpcode < 8'd192
      && regRdAddr == outOpcode[ADDR_W-1:0]) |-> (regRdData == outOperand[15:0])); // R6

endmodule

bind byte_cmd_decoder byte_cmd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inReady    (inReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outOpcode  (outOpcode),
  .outOperand (outOperand),
  .regRdAddr  (regRdAddr),
  .regRdData  (regRdData)
);

// File: tb/byte_cmd_decoder_bench.sv
`timescale 1ns/1ps
module byte_cmd_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [7:0]  outOpcode;
  logic [31:0] outOperand;
  logic [5:0]  regRdAddr = '0;
  logic [15:0] regRdData;

  int checks = 0;
  int failures = 0;
  logic [15:0] mdlReg [64];

  always #10 clk = ~clk;

  byte_cmd_decoder u_byte_cmd_decoder (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outOpcode(outOpcode),
    .outOperand(outOperand), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  function automatic int expLen(input logic [7:0] op);
    if (op < 8'd128) return 1;
    if (op < 8'd192) return 2;
    if (op < 8'd224) return 3;
    return 4;
  endfunction

  function automatic string lenReq(input logic [7:0] op);
    case (expLen(op))
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [31:0] expOperand(input logic [7:0] op, input logic [31:0] v);
    int n = expLen(op);
    if (n == 4) return v;
    return v & ((32'd1 << (8 * n)) - 32'd1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic putByte(input logic [7:0] b);
    @(negedge clk);
    inByte  = b;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
      inByte  = 8'($urandom);
    end
  endtask

  task automatic readReg(input logic [5:0] a);
    regRdAddr = a;
    #1;
    check(regRdData == mdlReg[a], "R6", "register readback", 32'(regRdData), 32'(mdlReg[a]));
  endtask

  task automatic sendCmd(input logic [7:0] op, input logic [31:0] val,
                         input int gapMax, input int hold);
    int n = expLen(op);
    logic [31:0] ev = expOperand(op, val);
    string rq = lenReq(op);
    putByte(op);
    for (int i = n - 1; i >= 0; i--) begin
      if (gapMax > 0) idle(int'($urandom % (gapMax + 1)));  // R8 gaps
      putByte(val[8*i +: 8]);
    end
    @(negedge clk);
    inValid = 1'b1;            // junk offered while busy, must be ignored (R8)
    inByte  = 8'($urandom);
    check(outValid == 1'b1, "R9", "outValid after last byte", 32'(outValid), 32'd1);
    check(outOpcode == op, rq, "opcode", 32'(outOpcode), 32'(op));
    check(outOperand == ev, rq, "operand", outOperand, ev);
    if (op >= 8'd128 && op < 8'd192) mdlReg[op[5:0]] = val[15:0];
    if (op >= 8'd128 && op < 8'd192) readReg(op[5:0]);   // R10
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      inByte = 8'($urandom);
      check(outValid && outOpcode == op && outOperand == ev, "R7", "held output",
            outOperand, ev);
      check(inReady == 1'b0, "R7", "inReady while stalled", 32'(inReady), 32'd0);
    end
    @(negedge clk);
    outReady = 1'b1;
    inValid  = 1'b0;
    @(negedge clk);
    outReady = 1'b0;
    check(outValid == 1'b0, "R9", "outValid after accept", 32'(outValid), 32'd0);
    check(inReady == 1'b1, "R9", "inReady after accept", 32'(inReady), 32'd1);
    readReg(6'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 64; i++) mdlReg[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid at reset", 32'(outValid), 32'd0);
    check(inReady == 1'b1, "R1", "inReady at reset", 32'(inReady), 32'd1);
    readReg(6'd0);
    readReg(6'd63);

    // directed range edges, junk in unused high bytes
    sendCmd(8'h00, 32'hAABBCC00, 0, 0);
    sendCmd(8'h7F, 32'h112233DD, 2, 1);
    sendCmd(8'h80, 32'h55668000, 0, 2);
    sendCmd(8'hBF, 32'hEEEE7FFF, 3, 0);
    sendCmd(8'hC0, 32'h99123456, 1, 3);
    sendCmd(8'hDF, 32'hFFABCDEF, 0, 0);
    sendCmd(8'hE0, 32'hDEADBEEF, 2, 1);
    sendCmd(8'hFF, 32'hFFFFFFFF, 0, 0);
    sendCmd(8'hA5, 32'h0000FACE, 0, 0);
    sendCmd(8'h25, 32'h000000FF, 0, 0);   // non-register opcode with same low bits
    readReg(6'h25);

    for (int k = 0; k < 300; k++)
      sendCmd(8'($urandom), $urandom, int'($urandom % 4), int'($urandom % 4));

    for (int i = 0; i < 64; i++) readReg(6'(i));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule